// File: doc/BRIEF.md
# Fragment Merging Readout Multiplexer

This block gathers event fragments that arrive on several input links and fuses the fragments that share one event number into a single output fragment. Each fragment begins with a header word. The upper half of the header holds the event number and the lower half holds the count of payload words that follow it. The merged fragment starts with its own header, which carries the common event number and the sum of all the input counts. The payload of every input follows in input order.

Data is only ever pushed. The inputs have no ready signal and take a word on every cycle their valid is high. Each input has its own buffer. When any buffer gets close to full, a throttle output is raised toward the trigger so that the sources pause, and no data is dropped.

Every unit works out the destination subfarm of a merged fragment in the same way, as the event number modulo the number of subfarms, so no central manager is needed. A build-time parameter selects one of two variants:
- Multiplexer mode has 16 inputs and 4-word buffers. Its output never stalls.
- Readout-unit mode has 4 inputs and 32-word buffers. Its output honours a ready signal from downstream.

Top module: `frag_merge_mux`

## Requirements
- R1: The header of a merged fragment is marked by out_sof. Its bits [31:16] hold the event number taken from input 0. Its bits [15:0] hold the sum, modulo 2^16, of the input counts in bits [15:0] of the input headers.
- R2: After the merged header, the payload words of input 0 come out first, then those of input 1, and so on. Each input's words keep their arrival order, and the number of payload words equals the summed count.
- R3: An input has no ready signal. It stores one word on every cycle its valid is high, including back-to-back cycles.
- R4: While the header is presented, out_dest equals the event number modulo N_SUB (N_SUB is 6 by default).
- R5: If the input headers disagree on the event number, out_bad is high with the merged header, and err_sticky goes high and stays high until reset. A later matching event has out_bad low.
- R6: throttle is high whenever any input buffer holds at least DEPTH-MARGIN words, which is 3 in multiplexer mode and 28 in readout-unit mode. It drops again once every buffer is below that level.
- R7: In multiplexer mode there are 16 inputs, and out_ready is ignored: every presented word is taken in the cycle it is valid.
- R8: In readout-unit mode there are 4 inputs. While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: After reset, out_valid, throttle and err_sticky are low.
- R10: An input whose count is zero adds only its header to the merge and no payload words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | One word present per input |
| in_data | input | N_IN*W | Input words, input i in bits [i*W +: W] |
| out_ready | input | 1 | Downstream ready (readout-unit mode only) |
| out_valid | output | 1 | Output word present |
| out_data | output | W | Merged header or payload word |
| out_sof | output | 1 | Output word is a merged header |
| out_bad | output | 1 | Merged header covers mismatched event numbers |
| out_dest | output | DW | Destination subfarm, valid with the header |
| throttle | output | 1 | Request to pause the sources |
| err_sticky | output | 1 | A mismatch has been seen since reset |

## Verification
Suppose a word count is loaded wrongly or the input selector steps wrongly. The next merged fragment would then come out with the wrong length or with words from the wrong input, and that would be visible within one fragment time of the header. The sum in the header and the payload tags, which encode the input and the word index, expose it at once. A buffer pointer fault would show up as repeated or missing tagged words, or as a throttle level that does not match the number of words written. Mismatch and stickiness are checked on the header of the bad event and again on the event that follows it.

// File: rtl/frag_merge_mux.sv
module frag_merge_mux #(
  parameter int RU_MODE = 0,
  parameter int W       = 32,
  parameter int N_SUB   = 6,
  localparam int N_IN   = (RU_MODE != 0) ? 4 : 16,
  localparam int DW     = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_valid,
  input  logic [N_IN*W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic              out_sof,
  output logic              out_bad,
  output logic [DW-1:0]     out_dest,
  output logic              throttle,
  output logic              err_sticky
);
  localparam int DEPTH  = (RU_MODE != 0) ? 32 : 4;
  localparam int MARGIN = (RU_MODE != 0) ? 4 : 1;
  localparam int AW     = $clog2(DEPTH);
  localparam int EW     = W / 2;
  localparam int SW     = $clog2(N_IN);
  localparam logic [AW:0]   THR  = (AW+1)'(DEPTH - MARGIN);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [EW-1:0] NS   = EW'(N_SUB);
  localparam logic [SW-1:0] LAST = SW'(N_IN - 1);

  typedef enum logic {S_HDR, S_BODY} st_t;

  logic [W-1:0]  head  [N_IN];
  logic [AW:0]   occ   [N_IN];
  logic [N_IN-1:0] empty, pop, near_full;
  logic [EW-1:0] cnt   [N_IN];
  logic [SW-1:0] sel;
  st_t           st;
  logic [EW-1:0] sum, ev0;
  logic          mism, rdy, fire;

  for (genvar g = 0; g < N_IN; g++) begin : g_buf
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk) begin
      if (in_valid[g]) mem[wp[AW-1:0]] <= in_data[g*W +: W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (in_valid[g]) wp <= wp + 1'b1;
        if (pop[g])      rp <= rp + 1'b1;
      end
    end

    assign occ[g]       = wp - rp;
    assign empty[g]     = (occ[g] == '0);
    assign head[g]      = mem[rp[AW-1:0]];
    assign near_full[g] = (occ[g] >= THR);
    assign pop[g]       = fire && (st == S_HDR || sel == SW'(g));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[g] && occ[g] == FULL && !pop[g]));
  end

  assign ev0 = head[0][W-1:EW];

  always_comb begin
    sum  = '0;
    mism = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      sum = sum + head[i][EW-1:0];
      if (head[i][W-1:EW] != ev0) mism = 1'b1;
    end
  end

  assign rdy        = (RU_MODE != 0) ? out_ready : 1'b1;
  assign out_valid  = (st == S_HDR) ? ~|empty : (cnt[sel] != '0 && !empty[sel]);
  assign out_data   = (st == S_HDR) ? {ev0, sum} : head[sel];
  assign out_sof    = (st == S_HDR);
  assign out_bad    = (st == S_HDR) && mism;
  assign out_dest   = DW'(ev0 % NS);
  assign fire       = out_valid && rdy;
  assign throttle   = |near_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HDR;
      sel        <= '0;
      err_sticky <= 1'b0;
      for (int i = 0; i < N_IN; i++) cnt[i] <= '0;
    end else if (st == S_HDR) begin
      if (fire) begin
        for (int i = 0; i < N_IN; i++) cnt[i] <= head[i][EW-1:0];
        sel <= '0;
        st  <= S_BODY;
        if (mism) err_sticky <= 1'b1;
      end
    end else begin
      if (cnt[sel] == '0) begin
        if (sel == LAST) st <= S_HDR;
        else             sel <= sel + 1'b1;
      end else if (fire) begin
        cnt[sel] <= cnt[sel] - 1'b1;
      end
    end
  end

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> $past(out_valid && out_sof && out_bad));

  // R4
  dest_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> int'(out_dest) < N_SUB);

  if (RU_MODE != 0) begin : g_ru_chk
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
  end else begin : g_mux_chk
    // R7
    no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sof |=> !out_sof);
  end
endmodule

// File: tb/frag_merge_mux_tb.sv
module frag_merge_mux_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0]  m_v = '0;
  logic [511:0] m_d = '0;
  logic m_ordy = 1'b0, m_ov, m_sof, m_bad, m_thr, m_err;
  logic [31:0] m_od;
  logic [2:0]  m_dest;

  logic [3:0]   r_v = '0;
  logic [127:0] r_d = '0;
  logic r_ordy = 1'b0, r_ov, r_sof, r_bad, r_thr, r_err;
  logic [31:0] r_od;
  logic [2:0]  r_dest;

  frag_merge_mux #(.RU_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(m_v), .in_data(m_d), .out_ready(m_ordy),
    .out_valid(m_ov), .out_data(m_od), .out_sof(m_sof), .out_bad(m_bad),
    .out_dest(m_dest), .throttle(m_thr), .err_sticky(m_err));

  frag_merge_mux #(.RU_MODE(1)) u_ru (
    .clk(clk), .rst_n(rst_n), .in_valid(r_v), .in_data(r_d), .out_ready(r_ordy),
    .out_valid(r_ov), .out_data(r_od), .out_sof(r_sof), .out_bad(r_bad),
    .out_dest(r_dest), .throttle(r_thr), .err_sticky(r_err));

  int nvec = 0, nfail = 0;
  logic [31:0] mq [0:1023];
  logic [4:0]  mf [0:1023];
  logic [31:0] rq [0:1023];
  logic [4:0]  rf [0:1023];
  int mn = 0, rn = 0;

  always @(negedge clk) begin
    if (rst_n && m_ov && mn < 1024) begin
      mq[mn] = m_od; mf[mn] = {m_sof, m_bad, m_dest}; mn++;
    end
    if (rst_n && r_ov && r_ordy && rn < 1024) begin
      rq[rn] = r_od; rf[rn] = {r_sof, r_bad, r_dest}; rn++;
    end
  end

  int ev [16];
  int ct [16];
  bit en [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int e, input int i, input int k);
    return {e[15:0], i[7:0], k[7:0]};
  endfunction

  task automatic drive(input bit ru);
    int n = ru ? 4 : 16;
    int mx = 0;
    for (int i = 0; i < n; i++) if (en[i] && ct[i] > mx) mx = ct[i];
    for (int k = 0; k <= mx; k++) begin
      @(posedge clk); #1;
      for (int i = 0; i < n; i++) begin
        logic vv = en[i] && (k <= ct[i]);
        logic [31:0] w = (k == 0) ? {ev[i][15:0], ct[i][15:0]} : pay(ev[i], i, k);
        if (ru) begin r_v[i] = vv; r_d[i*32 +: 32] = w; end
        else    begin m_v[i] = vv; m_d[i*32 +: 32] = w; end
      end
    end
    @(posedge clk); #1;
    m_v = '0; r_v = '0;
  endtask

  task automatic expect_event(input bit ru, input int start, input bit bad_exp, input string req);
    int n = ru ? 4 : 16;
    int sum = 0;
    int idx;
    logic [31:0] w;
    logic [4:0] f;
    for (int i = 0; i < n; i++) sum += ct[i];
    for (int c = 0; c < 2000; c++) begin
      if ((ru ? rn : mn) >= start + 1 + sum) break;
      @(posedge clk); #1;
      if (ru) r_ordy = ~r_ordy; else m_ordy = ~m_ordy;
      @(negedge clk);
    end
    w = ru ? rq[start] : mq[start];
    f = ru ? rf[start] : mf[start];
    check({req, " R1 header"}, w, {ev[0][15:0], sum[15:0]});
    check({req, " R1 sof"}, 32'(f[4]), 32'd1);
    check({req, " R5 bad"}, 32'(f[3]), 32'(bad_exp));
    check({req, " R4 dest"}, 32'(f[2:0]), 32'(ev[0] % 6));
    idx = start + 1;
    for (int i = 0; i < n; i++)
      for (int k = 1; k <= ct[i]; k++) begin
        w = ru ? rq[idx] : mq[idx];
        f = ru ? rf[idx] : mf[idx];
        check({req, " R2 payload"}, {w[31:0]}, pay(ev[i], i, k));
        check({req, " R2 no sof"}, 32'(f[4]), 32'd0);
        idx++;
      end
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 mux valid", 32'(m_ov), 0);
    check("R9 mux throttle", 32'(m_thr), 0);
    check("R9 mux err", 32'(m_err), 0);
    check("R9 ru valid", 32'(r_ov), 0);
    check("R9 ru throttle", 32'(r_thr), 0);
    check("R9 ru err", 32'(r_err), 0);
  endtask

  task automatic t_mux_basic;
    int s = mn;
    for (int i = 0; i < 16; i++) begin ev[i] = 10; ct[i] = i % 3; en[i] = 1; end
    drive(0);
    expect_event(0, s, 0, "R3 R7 R10 mux mixed");
    s = mn;
    for (int i = 0; i < 16; i++) begin ev[i] = 17; ct[i] = 2; end
    drive(0);
    expect_event(0, s, 0, "R7 mux full");
  endtask

  task automatic t_mux_mismatch;
    int s = mn;
    for (int i = 0; i < 16; i++) begin ev[i] = 23; ct[i] = 1; en[i] = 1; end
    ev[7] = 24;
    drive(0);
    expect_event(0, s, 1, "R5 mismatch");
    check("R5 sticky set", 32'(m_err), 1);
    s = mn;
    for (int i = 0; i < 16; i++) begin ev[i] = 30; ct[i] = 1; end
    drive(0);
    expect_event(0, s, 0, "R5 after mismatch");
    check("R5 sticky held", 32'(m_err), 1);
  endtask

  task automatic t_mux_throttle;
    int s = mn;
    for (int i = 0; i < 16; i++) begin ev[i] = 40; ct[i] = 1; en[i] = (i == 5); end
    ct[5] = 2;
    drive(0);
    @(negedge clk);
    check("R6 throttle high", 32'(m_thr), 1);
    check("R6 no output early", 32'(mn - s), 0);
    for (int i = 0; i < 16; i++) en[i] = (i != 5);
    drive(0);
    expect_event(0, s, 0, "R6 throttled event");
    @(negedge clk);
    check("R6 throttle low", 32'(m_thr), 0);
  endtask

  task automatic t_ru_backpressure;
    int s = rn;
    logic [31:0] held;
    r_ordy = 1'b0;
    for (int i = 0; i < 16; i++) begin ev[i] = 50; ct[i] = 0; en[i] = 1; end
    ct[0] = 3; ct[1] = 0; ct[2] = 5; ct[3] = 2;
    drive(1);
    repeat (2) @(negedge clk);
    check("R8 valid", 32'(r_ov), 1);
    held = r_od;
    repeat (3) @(negedge clk);
    check("R8 still valid", 32'(r_ov), 1);
    check("R8 data held", r_od, held);
    check("R8 held header", held, 32'h0032000A);
    expect_event(1, s, 0, "R8 ru stream");
    s = rn;
    for (int i = 0; i < 4; i++) begin ev[i] = 61; ct[i] = 20; end
    drive(1);
    @(negedge clk);
    check("R6 ru below level", 32'(r_thr), 0);
    expect_event(1, s, 0, "R3 ru deep");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mux_basic();
    t_mux_mismatch();
    t_mux_throttle();
    t_ru_backpressure();
    repeat (4) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule